// File: doc/BRIEF.md
# Per-Channel Input Interrupt Detector

This block watches a set of digital input lines (twelve by default) and raises a pending flag per channel when that channel's programmed condition is met. Each raw line first passes through a synchronizer. The block then compares the settled sample with the sample from one cycle earlier. Software picks one of two trigger kinds for each channel. The change kind fires on any transition, rising or falling. The level kind fires while the input equals a chosen polarity.

Three per-channel control registers hold the enable mask, the trigger kind and the polarity. Each has its own write strobe and takes a full-width data word. Pending flags are cleared by writing ones. While a level condition persists, its flag raises again straight after the clear, so the interrupt cannot be lost. A single request output is active whenever any flag is pending. Bus decoding and vector formation are left to the surrounding logic.

Top module: `chan_irq_detect`

## Requirements
- R1: Channel i is controlled by bit i of every write-data word and reported on bit i of `pending`. Activity on one channel never sets another channel's flag.
- R2: A channel whose enable bit is 0 never sets its pending flag, whatever its input does.
- R3: With kind bit 1 (change), both a rising and a falling transition of the synchronized input set the flag.
- R4: With kind bit 0 (level), the flag sets while the input is low if the polarity bit is 0, and while it is high if the polarity bit is 1. Polarity has no effect in change mode.
- R5: Writing 1 to a bit of the clear word drops that pending flag. A 0 bit leaves its flag unchanged.
- R6: If an enabled level condition still holds when its flag is cleared, the flag stays set. Once the channel is disabled, the clear takes effect.
- R7: After reset, every control register and every pending flag is zero, so no flag is set even while inputs sit low.
- R8: A transition on an input shows on `pending` after the third rising clock edge following it (two synchronizer stages plus the status register). `irq` changes in the same cycle as `pending`.
- R9: When a set condition and a write-1 clear hit the same bit at the same edge, the flag ends up set.
- R10: `irq` is high exactly when at least one pending flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_in | input | NUM_CH | Raw asynchronous channel lines |
| en_we | input | 1 | Write strobe for the enable mask |
| en_wdata | input | NUM_CH | Enable mask data, 1 = channel may interrupt |
| kind_we | input | 1 | Write strobe for the trigger-kind register |
| kind_wdata | input | NUM_CH | Trigger kind data, 1 = change, 0 = level |
| pol_we | input | 1 | Write strobe for the polarity register |
| pol_wdata | input | NUM_CH | Polarity data, 1 = high level, 0 = low level |
| clr_we | input | 1 | Write strobe for clearing pending flags |
| clr_wdata | input | NUM_CH | Clear mask, 1 = drop that flag |
| pending | output | NUM_CH | Per-channel pending flags |
| irq | output | 1 | Combined request, OR of all flags |

## Verification
Inputs held low against the reset configuration separate masking from level matching. Held levels under clear writes show whether a persisting condition re-raises its flag, and whether disabling stops it. A single channel toggled in each direction shows whether both edges count, how many cycles the latency takes, and whether other channels stay quiet. A clear timed onto the same edge as a new event tells set-priority apart from clear-priority. A long run of random inputs, configurations and clears is then checked every clock against a behavioural model built from the input history.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;

    typedef enum logic {
        TRIG_LEVEL  = 1'b0,
        TRIG_CHANGE = 1'b1
    } trig_kind_e;

    // Decide whether one channel's condition holds this cycle.
    function automatic logic chan_hit(input trig_kind_e kind,
                                      input logic       pol,
                                      input logic       cur,
                                      input logic       prev);
        logic hit;
        if (kind == TRIG_CHANGE) begin
            hit = cur ^ prev;
        end else begin
            hit = ~(cur ^ pol);
        end
        return hit;
    endfunction

endpackage

// File: rtl/chan_irq_sync.sv
module chan_irq_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
        logic [W-1:0]             old;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stg[0] = raw;
        for (int k = 1; k < STAGES; k++) begin
            s_d.stg[k] = s_q.stg[k-1];
        end
        s_d.old = s_q.stg[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur  = s_q.stg[LAST];
    assign prev = s_q.old;

endmodule

// File: rtl/chan_irq_cfg.sv
module chan_irq_cfg #(
    parameter int NUM_CH = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we,
    input  logic [NUM_CH-1:0] en_wdata,
    input  logic              kind_we,
    input  logic [NUM_CH-1:0] kind_wdata,
    input  logic              pol_we,
    input  logic [NUM_CH-1:0] pol_wdata,
    output logic [NUM_CH-1:0] en,
    output logic [NUM_CH-1:0] kind,
    output logic [NUM_CH-1:0] pol
);
    typedef struct packed {
        logic [NUM_CH-1:0] en;
        logic [NUM_CH-1:0] kind;
        logic [NUM_CH-1:0] pol;
    } cfg_state_t;

    cfg_state_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (en_we)   c_d.en   = en_wdata;
        if (kind_we) c_d.kind = kind_wdata;
        if (pol_we)  c_d.pol  = pol_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign en   = c_q.en;
    assign kind = c_q.kind;
    assign pol  = c_q.pol;

endmodule

// File: rtl/chan_irq_cell.sv
module chan_irq_cell
    import chan_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  trig_kind_e kind,
    input  logic       pol,
    input  logic       cur,
    input  logic       prev,
    input  logic       clr,
    output logic       set_o,
    output logic       pend_o
);
    typedef struct packed {
        logic pend;
    } cell_state_t;

    cell_state_t p_d, p_q;
    logic        set_now;

    always_comb begin
        set_now    = en & chan_hit(kind, pol, cur, prev);
        p_d        = p_q;
        // set has priority over a simultaneous clear
        p_d.pend   = (p_q.pend & ~clr) | set_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign set_o  = set_now;
    assign pend_o = p_q.pend;

endmodule

// File: rtl/chan_irq_detect.sv
module chan_irq_detect
    import chan_irq_pkg::*;
#(
    parameter int NUM_CH      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_in,
    input  logic              en_we,
    input  logic [NUM_CH-1:0] en_wdata,
    input  logic              kind_we,
    input  logic [NUM_CH-1:0] kind_wdata,
    input  logic              pol_we,
    input  logic [NUM_CH-1:0] pol_wdata,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] clr_wdata,
    output logic [NUM_CH-1:0] pending,
    output logic              irq
);
    logic [NUM_CH-1:0] sync_cur;
    logic [NUM_CH-1:0] sync_prev;
    logic [NUM_CH-1:0] cfg_en;
    logic [NUM_CH-1:0] cfg_kind;
    logic [NUM_CH-1:0] cfg_pol;
    logic [NUM_CH-1:0] clr_vec;
    logic [NUM_CH-1:0] set_vec;

    chan_irq_sync #(
        .W      (NUM_CH),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (chan_in),
        .cur   (sync_cur),
        .prev  (sync_prev)
    );

    chan_irq_cfg #(
        .NUM_CH (NUM_CH)
    ) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_we      (en_we),
        .en_wdata   (en_wdata),
        .kind_we    (kind_we),
        .kind_wdata (kind_wdata),
        .pol_we     (pol_we),
        .pol_wdata  (pol_wdata),
        .en         (cfg_en),
        .kind       (cfg_kind),
        .pol        (cfg_pol)
    );

    assign clr_vec = clr_we ? clr_wdata : '0;

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_cell
        chan_irq_cell cell_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (cfg_en[gi]),
            .kind   (trig_kind_e'(cfg_kind[gi])),
            .pol    (cfg_pol[gi]),
            .cur    (sync_cur[gi]),
            .prev   (sync_prev[gi]),
            .clr    (clr_vec[gi]),
            .set_o  (set_vec[gi]),
            .pend_o (pending[gi])
        );
    end

    assign irq = |pending;

endmodule

// File: rtl/chan_irq_detect_chk.sv
module chan_irq_detect_chk #(
    parameter int NUM_CH = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_we,
    input logic [NUM_CH-1:0] clr_wdata,
    input logic [NUM_CH-1:0] pending,
    input logic              irq,
    input logic [NUM_CH-1:0] cfg_en,
    input logic [NUM_CH-1:0] cfg_kind,
    input logic [NUM_CH-1:0] set_vec,
    input logic [NUM_CH-1:0] sync_cur,
    input logic [NUM_CH-1:0] sync_prev
);
    AST_MASKED_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (pending & ~$past(pending) & ~$past(cfg_en)) == '0); // R2

    AST_CHANGE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (pending & ~$past(pending) & $past(cfg_kind) & ~$past(sync_cur ^ sync_prev)) == '0); // R3

    AST_DROP_ONLY_BY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pending) & ~pending & ~($past(clr_we) ? $past(clr_wdata) : '0)) == '0); // R5

    AST_LEVEL_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(set_vec & ~cfg_kind) & ~pending) == '0); // R6

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(set_vec) & ~pending) == '0); // R9

    AST_IRQ_FALL_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(clr_we)); // R10

endmodule

bind chan_irq_detect chan_irq_detect_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_we    (clr_we),
    .clr_wdata (clr_wdata),
    .pending   (pending),
    .irq       (irq),
    .cfg_en    (cfg_en),
    .cfg_kind  (cfg_kind),
    .set_vec   (set_vec),
    .sync_cur  (sync_cur),
    .sync_prev (sync_prev)
);

// File: tb/chan_irq_detect_tb.sv
module chan_irq_detect_tb_top;
    localparam int N = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] din = '0;
    logic         en_we = 1'b0, kind_we = 1'b0, pol_we = 1'b0, clr_we = 1'b0;
    logic [N-1:0] en_wd = '0, kind_wd = '0, pol_wd = '0, clr_wd = '0;
    logic [N-1:0] pending;
    logic         irq;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    cmp_on = 1'b0;
    string cur_req = "R7";

    // behavioural reference state
    logic [N-1:0] m_en, m_kind, m_pol, m_pend;
    logic [N-1:0] h1, h2, h3;

    always #10 clk = ~clk;

    chan_irq_detect #(.NUM_CH(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_in    (din),
        .en_we      (en_we),
        .en_wdata   (en_wd),
        .kind_we    (kind_we),
        .kind_wdata (kind_wd),
        .pol_we     (pol_we),
        .pol_wdata  (pol_wd),
        .clr_we     (clr_we),
        .clr_wdata  (clr_wd),
        .pending    (pending),
        .irq        (irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0; m_kind = '0; m_pol = '0; m_pend = '0;
            h1 = '0; h2 = '0; h3 = '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                bit hit;
                if (m_kind[i]) hit = (h2[i] != h3[i]);
                else           hit = (h2[i] == m_pol[i]);
                m_pend[i] = (m_pend[i] && !(clr_we && clr_wd[i])) || (m_en[i] && hit);
            end
            if (en_we)   m_en   = en_wd;
            if (kind_we) m_kind = kind_wd;
            if (pol_we)  m_pol  = pol_wd;
            h3 = h2; h2 = h1; h1 = din;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            n_chk++;
            if (pending !== m_pend || irq !== (m_pend != '0)) begin
                n_fail++;
                $display("FAIL %s model: pending=%h irq=%b expected pending=%h irq=%b",
                         cur_req, pending, irq, m_pend, (m_pend != '0));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [N-1:0] exp_p);
        n_chk++;
        if (pending !== exp_p || irq !== (exp_p != '0)) begin
            n_fail++;
            $display("FAIL %s: pending=%h irq=%b expected pending=%h irq=%b",
                     req, pending, irq, exp_p, (exp_p != '0));
        end
    endtask

    task automatic wr_en(input logic [N-1:0] v);
        en_we = 1'b1; en_wd = v; tick(1); en_we = 1'b0;
    endtask
    task automatic wr_kind(input logic [N-1:0] v);
        kind_we = 1'b1; kind_wd = v; tick(1); kind_we = 1'b0;
    endtask
    task automatic wr_pol(input logic [N-1:0] v);
        pol_we = 1'b1; pol_wd = v; tick(1); pol_we = 1'b0;
    endtask
    task automatic wr_clr(input logic [N-1:0] v);
        clr_we = 1'b1; clr_wd = v; tick(1); clr_we = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: run did not finish, expected completion");
                $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
                $finish;
            end
        join_none

        tick(3);
        rst_n = 1'b1;
        tick(1);
        cmp_on = 1'b1;
        tick(3);
        // R7: reset values, inputs low yet masked
        check("R7", '0);

        cur_req = "R2 R4";
        wr_en('1);
        tick(0);
        check("R2", '0);
        tick(1);
        // R4: level low, polarity 0, inputs low
        check("R4", 12'hFFF);

        cur_req = "R6";
        wr_clr('1);
        check("R6", 12'hFFF);

        cur_req = "R5";
        din = '1;
        tick(3);
        wr_clr('1);
        check("R5", '0);

        cur_req = "R4";
        wr_kind('1);
        wr_pol('1);
        tick(3);
        // R4: high inputs with polarity 1 but change mode selected
        check("R4", '0);

        cur_req = "R8 R3";
        din[3] = 1'b0;
        tick(2);
        check("R8", '0);
        tick(1);
        check("R8", 12'h008);
        check("R1", 12'h008);

        cur_req = "R5";
        wr_clr(12'hFF7);
        check("R5", 12'h008);
        wr_clr(12'h008);
        check("R5", '0);

        cur_req = "R3";
        din[3] = 1'b1;
        tick(3);
        check("R3", 12'h008);
        wr_clr(12'h008);

        cur_req = "R9";
        din[3] = 1'b0;
        tick(2);
        wr_clr(12'h008);
        check("R9", 12'h008);
        tick(1);
        wr_clr(12'h008);
        check("R9", '0);

        cur_req = "R2";
        wr_en('0);
        wr_clr('1);
        for (int k = 0; k < 12; k++) begin
            din = N'($urandom);
            tick(1);
        end
        tick(3);
        check("R2", '0);

        cur_req = "R4 R6";
        wr_kind('0);
        wr_pol(12'h0F0);
        din = 12'h00F;
        wr_en('1);
        tick(4);
        wr_clr('1);
        check("R4", 12'hF00);
        check("R6", 12'hF00);
        wr_en('0);
        wr_clr('1);
        check("R6", '0);

        cur_req = "R1 R10";
        for (int k = 0; k < 400; k++) begin
            din = N'($urandom);
            if (k % 50 == 0) begin
                en_we = 1'b1; en_wd = N'($urandom);
                kind_we = 1'b1; kind_wd = N'($urandom);
                pol_we = 1'b1; pol_wd = N'($urandom);
            end
            clr_we = ($urandom % 4) == 0;
            clr_wd = N'($urandom);
            tick(1);
            en_we = 1'b0; kind_we = 1'b0; pol_we = 1'b0; clr_we = 1'b0;
        end
        tick(4);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule